// File: doc/BRIEF.md
# Bus Hang Watchdog

This block sits between a pipelined Wishbone master and the rest of the bus. It watches the master's cycle and strobe lines and the slave side's stall and acknowledge lines. While the master keeps its cycle open, a counter runs on every clock in which nothing moves forward. A clock moves forward when a request is accepted (strobe high, stall low) or when an acknowledge returns. The counter also runs while the master holds the cycle with its strobe low, for example while it waits for more data between two writes.

When the counter reaches a limit set at build time, the block sends a one-clock error to the master in place of an acknowledge. It then pulls the cycle and strobe low on the slave side, so the hung transaction is released. That release lasts until the master drops its own cycle line. Any clock that moves forward restarts the count. A long cycle with many transfers is therefore legal, provided that no gap between two forward steps reaches the limit.

Top module: `bus_watchdog`

## Requirements
- R1: After a synchronous active-high reset, `mst_err` is low and the slave-side lines follow the master: `slv_cyc`=`mst_cyc` and `slv_stb`=`mst_stb`.
- R2: When no release is in force, `slv_cyc`=`mst_cyc`, `slv_stb`=`mst_stb`, `mst_stall`=`slv_stall` and `mst_ack`=`slv_ack`.
- R3: Count the rising edges at which `mst_cyc` is high and none of the forward events below occur. If `TIMEOUT` such edges come one after another, `mst_err` is high in the cycle after the `TIMEOUT`-th edge and is low after every earlier one.
- R4: An edge with an accepted request (`mst_stb`=1 and `slv_stall`=0) or with `slv_ack`=1 restarts the count from zero.
- R5: An edge with `mst_cyc` low restarts the count from zero.
- R6: Clocks in which `mst_cyc` is high and `mst_stb` is low count toward the timeout.
- R7: `mst_err` is high for exactly one clock per timeout.
- R8: From the clock in which `mst_err` rises until the first edge with `mst_cyc` low, the block forces `slv_cyc`=0, `slv_stb`=0, `mst_stall`=1 and `mst_ack`=0. Acknowledges that arrive during this time are ignored.
- R9: If `slv_ack` is high at the edge that would otherwise expire, no error follows and the count restarts.
- R10: `TIMEOUT` is a parameter held in a counter at least 30 bits wide. Its default is 500,000,000 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mst_cyc | input | 1 | Cycle line from the master |
| mst_stb | input | 1 | Strobe from the master |
| mst_stall | output | 1 | Stall returned to the master |
| mst_ack | output | 1 | Acknowledge returned to the master |
| mst_err | output | 1 | Timeout error pulse to the master |
| slv_cyc | output | 1 | Cycle line toward the slaves, low while released |
| slv_stb | output | 1 | Strobe toward the slaves, low while released |
| slv_stall | input | 1 | Stall from the slave side |
| slv_ack | input | 1 | Acknowledge from the slave side |

## Verification
The hardest case to reach is an acknowledge that arrives on exactly the edge at which the count would expire. Random traffic almost never lines up like that. The bench builds it directly: it holds a cycle stalled for `TIMEOUT`-1 edges and then pulses the acknowledge. It also covers long cycles whose accepted requests are spaced just below the limit. Random traffic with a bias toward long stalls and strobe-low gaps then reaches timeouts, releases, and acknowledges during a release, and a reference model in the bench checks every cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef struct packed {
        logic cyc;
        logic stb;
    } mreq_t;

    typedef struct packed {
        logic stall;
        logic ack;
    } sresp_t;

    // A clock moves the bus forward when a request is taken or a reply returns.
    function automatic logic moves_forward(mreq_t req, sresp_t rsp);
        return (req.stb && !rsp.stall) || rsp.ack;
    endfunction

endpackage

// File: rtl/wdg_monitor.sv
module wdg_monitor
    import wdg_pkg::*;
(
    input  mreq_t  req,
    input  sresp_t rsp,
    input  logic   released,
    output logic   active,
    output logic   progress
);
    always_comb begin
        active   = req.cyc && !released;
        progress = moves_forward(req, rsp);
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int          CNT_W   = 30,
    parameter logic [63:0] TIMEOUT = 64'd500_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic progress,
    output logic expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 64'd1);

    logic [CNT_W-1:0] stuck_cnt;

    always_comb expire = active && !progress && (stuck_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active || progress || expire) begin
            stuck_cnt <= '0;
        end else begin
            stuck_cnt <= stuck_cnt + 1'b1;
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stuck_cnt <= LAST);

    // R5
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> stuck_cnt == '0);
endmodule

// File: rtl/wdg_release.sv
module wdg_release (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic mst_cyc,
    output logic err_pulse,
    output logic released
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse <= 1'b0;
            released  <= 1'b0;
        end else begin
            err_pulse <= expire;
            if (expire)
                released <= 1'b1;
            else if (!mst_cyc)
                released <= 1'b0;
        end
    end

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    // R8
    err_releases_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> released);

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        released && mst_cyc |=> released);
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import wdg_pkg::*;
#(
    parameter int          CNT_W   = 30,
    parameter logic [63:0] TIMEOUT = 64'd500_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic mst_cyc,
    input  logic mst_stb,
    output logic mst_stall,
    output logic mst_ack,
    output logic mst_err,
    output logic slv_cyc,
    output logic slv_stb,
    input  logic slv_stall,
    input  logic slv_ack
);
    mreq_t  req;
    sresp_t rsp;
    logic   active, progress, expire, released, err_pulse;

    always_comb begin
        req.cyc   = mst_cyc;
        req.stb   = mst_stb;
        rsp.stall = slv_stall;
        rsp.ack   = slv_ack;
    end

    wdg_monitor i_monitor (
        .req      (req),
        .rsp      (rsp),
        .released (released),
        .active   (active),
        .progress (progress)
    );

    wdg_counter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) i_counter (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .progress (progress),
        .expire   (expire)
    );

    wdg_release i_release (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .mst_cyc   (mst_cyc),
        .err_pulse (err_pulse),
        .released  (released)
    );

    always_comb begin
        slv_cyc   = mst_cyc && !released;
        slv_stb   = mst_stb && !released;
        mst_stall = slv_stall || released;
        mst_ack   = slv_ack && !released;
        mst_err   = err_pulse;
    end

    // R10
    width_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (CNT_W >= 30) && (TIMEOUT >= 64'd1));

    // R9
    ack_wins_chk: assert property (@(posedge clk) disable iff (rst)
        slv_ack && slv_cyc |=> !mst_err);

    // R8
    err_drops_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        mst_err |-> !slv_cyc && !slv_stb && mst_stall && !mst_ack);

    // R3
    err_needs_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        mst_err |-> $past(slv_cyc));
endmodule

// File: tb/test_bus_watchdog.sv
module test_bus_watchdog;
    localparam int LIM = 12;

    logic clk = 1'b0;
    logic rst;
    logic mst_cyc, mst_stb, slv_stall, slv_ack;
    logic mst_stall, mst_ack, mst_err, slv_cyc, slv_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit model_on = 1'b0;

    always #2.5 clk = ~clk;

    bus_watchdog #(.CNT_W(30), .TIMEOUT(64'(LIM))) i_bus_watchdog (
        .clk, .rst, .mst_cyc, .mst_stb, .mst_stall, .mst_ack, .mst_err,
        .slv_cyc, .slv_stb, .slv_stall, .slv_ack
    );

    // Reference model built from the requirements
    int  m_cnt;
    bit  m_rel, m_err;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_rel <= 0; m_err <= 0;
        end else begin
            automatic bit act  = mst_cyc && !m_rel;
            automatic bit prog = (mst_stb && !slv_stall) || slv_ack;
            m_err <= 0;
            if (!mst_cyc) m_rel <= 0;
            if (!act || prog) m_cnt <= 0;
            else if (m_cnt == LIM - 1) begin
                m_err <= 1; m_rel <= 1; m_cnt <= 0;
            end else m_cnt <= m_cnt + 1;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic exp_scyc(bit rel, logic c);
        return c && !rel;
    endfunction

    task automatic chk_model();
        chk("R3 err", mst_err, m_err);
        chk("R2 slv_cyc", slv_cyc, exp_scyc(m_rel, mst_cyc));
        chk("R2 slv_stb", slv_stb, exp_scyc(m_rel, mst_stb));
        chk("R8 stall", mst_stall, slv_stall || m_rel);
        chk("R8 ack", mst_ack, slv_ack && !m_rel);
    endtask

    task automatic drive(logic c, logic s, logic st, logic a);
        mst_cyc = c; mst_stb = s; slv_stall = st; slv_ack = a;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) if (model_on) chk_model();

    initial begin
        void'($urandom(32'd1234));
        drive(0, 0, 0, 0);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 err", mst_err, 0);
        drive(1, 1, 1, 0);
        #1;
        chk("R1 slv_cyc", slv_cyc, 1);
        chk("R1 slv_stb", slv_stb, 1);
        drive(0, 0, 0, 0);
        step();

        // R3/R6: cycle held with strobe low, error after exactly LIM edges
        drive(1, 0, 0, 0);
        for (int k = 1; k <= LIM; k++) begin
            step();
            chk("R3 timing", mst_err, k == LIM);
        end
        chk("R8 slv_cyc low", slv_cyc, 0);
        chk("R8 stall high", mst_stall, 1);
        slv_ack = 1; #1;
        chk("R8 ack ignored", mst_ack, 0);
        slv_ack = 0;
        step();
        chk("R7 single pulse", mst_err, 0);
        chk("R8 still released", slv_cyc, 0);
        drive(0, 0, 0, 0);
        step();
        drive(1, 0, 0, 0); #1;
        chk("R8 release ends", slv_cyc, 1);

        // R9: ack on the expiring edge wins
        drive(1, 1, 1, 0);
        step();
        drive(1, 0, 1, 0);
        for (int k = 2; k < LIM; k++) step();
        slv_ack = 1;
        step();
        chk("R9 no error", mst_err, 0);
        slv_ack = 0;
        for (int k = 1; k < LIM; k++) step();
        chk("R9 restart no early err", mst_err, 0);
        step();
        chk("R9 restart full window", mst_err, 1);
        drive(0, 0, 0, 0);
        step();

        // R4: requests accepted every LIM-1 edges keep a long cycle alive
        drive(1, 0, 0, 0);
        for (int r = 0; r < 5; r++) begin
            for (int k = 0; k < LIM - 2; k++) begin
                step();
                chk("R4 long cycle", mst_err, 0);
            end
            mst_stb = 1; step(); mst_stb = 0;
            chk("R4 accept clears", mst_err, 0);
        end
        // R5: a drop of the cycle line restarts the count
        for (int k = 0; k < LIM - 2; k++) step();
        mst_cyc = 0; step(); mst_cyc = 1;
        for (int k = 0; k < LIM - 1; k++) begin
            step();
            chk("R5 idle clears", mst_err, 0);
        end
        drive(0, 0, 0, 0);
        step();

        // Random traffic checked against the model
        rst = 1; step(); rst = 0;
        model_on = 1;
        for (int i = 0; i < 3000; i++) begin
            automatic int r = $urandom_range(0, 99);
            if (r < 4) mst_cyc = ~mst_cyc;
            mst_stb   = ($urandom_range(0, 99) < 30);
            slv_stall = ($urandom_range(0, 99) < 85);
            slv_ack   = ($urandom_range(0, 99) < 4);
            step();
        end
        model_on = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule